// File: doc/BRIEF.md
# Lockable TLB Entry Manager

A small, fully associative translation lookaside buffer that software fills and maintains through a word-wide register port. Software places a virtual tag in two CAM staging registers and a physical page plus access permission in two RAM staging registers. It points a lock index at a slot and then issues a command that either copies the staging registers into that slot or copies the slot back into the staging registers. Translation is a combinational lookup: a 22-bit virtual page number (address bits [31:10], 1 KiB pages) goes in, and hit, miss, permission fault, physical page and permission come out in the same cycle.

A base register splits the buffer in two. Slots whose index is below the base are protected: a global flush leaves them alone, and the replacement pointer never points at them. The replacement pointer (the current victim) steps round-robin through the unprotected slots each time a lookup misses. Software reads it when it refills a slot after a miss. A single-slot flush clears the slot at the lock index, whether or not it is protected.

Top module: `tlb_lock_mgr`

## Requirements
- R1: A write of 1 to the command register (address 4) copies the staging registers into the slot at the lock index (address 5) in that same clock edge. The staging registers are: CAM high (address 0) = VA[31:16]; CAM low (address 1) = VA[15:10] in bits [15:10] and the valid flag in bit 0; RAM high (address 2) = PA[31:16]; RAM low (address 3) = PA[15:10] in bits [15:10] and the permission in bits [9:8].
- R2: A write of 2 to the command register copies the slot at the lock index back into the four staging registers, using the field positions of R1. The slot's valid flag appears in bit 0 of CAM low.
- R3: A lookup whose page number equals the tag of a valid slot asserts hit and returns that slot's physical page and permission in the same cycle. If several slots match, the lowest index wins.
- R4: A requested lookup that matches no valid slot asserts miss, and hit and miss are never both high.
- R5: Permission codes are 00 no access, 10 read-only and 11 full access; 01 is treated as no access. A hit raises fault when the code is 00 or 01, or when it is 10 and the access is a write. Fault is never raised without a hit.
- R6: A write of 1 to the global flush register (address 8) clears the valid flag of every slot whose index is at or above the base (address 6). Slots below the base keep their contents.
- R7: A write of 1 to the single-flush register (address 9) clears the valid flag of the slot at the lock index, even when that slot is below the base.
- R8: The current victim (address 7, read-only) is never below the base. Each cycle with a lookup miss moves it to the next index, or to the base after the last slot. A base write that lands above the victim pulls the victim up to the new base.
- R9: The command and both flush registers act only in the cycle they are written and read back as 0.
- R10: Reset clears every valid flag, the staging registers, the lock index, the base and the victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write address |
| reg_wdata | input | 16 | Register write data |
| reg_raddr | input | 4 | Register read address |
| reg_rdata | output | 16 | Register read data (combinational) |
| lk_req | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is for a write access |
| lk_vpn | input | 22 | Virtual page number, VA[31:10] |
| lk_hit | output | 1 | Lookup matched a valid slot |
| lk_miss | output | 1 | Requested lookup matched nothing |
| lk_fault | output | 1 | Permission fault on the hit slot |
| lk_ppn | output | 22 | Physical page number, PA[31:10] |
| lk_perm | output | 2 | Permission of the hit slot |

## Verification
The assertions check on every cycle that hit and miss exclude each other, that a fault only comes with a hit, and that the victim stays at or above the base and steps correctly after each miss. They also check that a global flush leaves no valid slot above the base and that a single-slot flush always empties its target. Only the bench scenarios can show that data passes correctly from the staging registers into a slot and back, that the returned physical pages are correct, and that protected slots still translate after a global flush. The same holds for the victim wrapping from the last slot back to a non-zero base and for the state after reset.

// File: rtl/tlb_lock_pkg.sv
package tlb_lock_pkg;

    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 4;
    localparam int VA_W       = 32;
    localparam int PAGE_SHIFT = 10;
    localparam int TAG_W      = VA_W - PAGE_SHIFT;
    localparam int LO_W       = TAG_W - DATA_W;
    localparam int LO_MSB     = DATA_W - 1;
    localparam int LO_LSB     = DATA_W - LO_W;

    typedef enum logic [1:0] {
        PERM_NONE = 2'b00,
        PERM_RSVD = 2'b01,
        PERM_RO   = 2'b10,
        PERM_RW   = 2'b11
    } perm_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_CAM_HI = 4'd0,
        REG_CAM_LO = 4'd1,
        REG_RAM_HI = 4'd2,
        REG_RAM_LO = 4'd3,
        REG_CMD    = 4'd4,
        REG_LOCK   = 4'd5,
        REG_BASE   = 4'd6,
        REG_VICTIM = 4'd7,
        REG_GFLUSH = 4'd8,
        REG_EFLUSH = 4'd9
    } reg_addr_e;

    localparam logic [DATA_W-1:0] CMD_LOAD = 16'd1;
    localparam logic [DATA_W-1:0] CMD_READ = 16'd2;
    localparam logic [DATA_W-1:0] CMD_GO   = 16'd1;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] vtag;
        logic [TAG_W-1:0] ppn;
        perm_e            perm;
    } tlb_entry_t;

    function automatic logic perm_fault(perm_e p, logic is_wr);
        return (p == PERM_NONE) || (p == PERM_RSVD) || (is_wr && (p == PERM_RO));
    endfunction

endpackage

// File: rtl/tlb_regs.sv
module tlb_regs
    import tlb_lock_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_waddr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [ADDR_W-1:0] reg_raddr,
    output logic [DATA_W-1:0] reg_rdata,
    input  tlb_entry_t        rb_entry,
    input  logic [IDX_W-1:0]  victim,
    output tlb_entry_t        stage,
    output logic [IDX_W-1:0]  lock_q,
    output logic [IDX_W-1:0]  base_q,
    output logic              base_we,
    output logic [IDX_W-1:0]  base_new,
    output logic              do_load,
    output logic              do_read,
    output logic              do_gflush,
    output logic              do_eflush
);

    logic [DATA_W-1:0] cam_hi_q;
    logic [LO_W-1:0]   cam_lo_q;
    logic              cam_v_q;
    logic [DATA_W-1:0] ram_hi_q;
    logic [LO_W-1:0]   ram_lo_q;
    perm_e             perm_q;

    // Command strobes exist only in the cycle of the write.
    assign do_load   = reg_we && (reg_waddr == REG_CMD)    && (reg_wdata == CMD_LOAD);
    assign do_read   = reg_we && (reg_waddr == REG_CMD)    && (reg_wdata == CMD_READ);
    assign do_gflush = reg_we && (reg_waddr == REG_GFLUSH) && (reg_wdata == CMD_GO);
    assign do_eflush = reg_we && (reg_waddr == REG_EFLUSH) && (reg_wdata == CMD_GO);
    assign base_we   = reg_we && (reg_waddr == REG_BASE);
    assign base_new  = reg_wdata[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cam_hi_q <= '0;
            cam_lo_q <= '0;
            cam_v_q  <= 1'b0;
            ram_hi_q <= '0;
            ram_lo_q <= '0;
            perm_q   <= PERM_NONE;
            lock_q   <= '0;
            base_q   <= '0;
        end else begin
            if (do_read) begin
                cam_hi_q <= rb_entry.vtag[TAG_W-1:LO_W];
                cam_lo_q <= rb_entry.vtag[LO_W-1:0];
                cam_v_q  <= rb_entry.valid;
                ram_hi_q <= rb_entry.ppn[TAG_W-1:LO_W];
                ram_lo_q <= rb_entry.ppn[LO_W-1:0];
                perm_q   <= rb_entry.perm;
            end
            if (reg_we) begin
                case (reg_waddr)
                    REG_CAM_HI: cam_hi_q <= reg_wdata;
                    REG_CAM_LO: begin
                        cam_lo_q <= reg_wdata[LO_MSB:LO_LSB];
                        cam_v_q  <= reg_wdata[0];
                    end
                    REG_RAM_HI: ram_hi_q <= reg_wdata;
                    REG_RAM_LO: begin
                        ram_lo_q <= reg_wdata[LO_MSB:LO_LSB];
                        perm_q   <= perm_e'(reg_wdata[9:8]);
                    end
                    REG_LOCK:   lock_q <= reg_wdata[IDX_W-1:0];
                    REG_BASE:   base_q <= reg_wdata[IDX_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        stage.valid = cam_v_q;
        stage.vtag  = {cam_hi_q, cam_lo_q};
        stage.ppn   = {ram_hi_q, ram_lo_q};
        stage.perm  = perm_q;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_raddr)
            REG_CAM_HI: reg_rdata = cam_hi_q;
            REG_CAM_LO: reg_rdata = {cam_lo_q, {(LO_LSB-1){1'b0}}, cam_v_q};
            REG_RAM_HI: reg_rdata = ram_hi_q;
            REG_RAM_LO: reg_rdata = {ram_lo_q, {(LO_LSB-10){1'b0}}, perm_q, 8'h00};
            REG_LOCK:   reg_rdata = {{(DATA_W-IDX_W){1'b0}}, lock_q};
            REG_BASE:   reg_rdata = {{(DATA_W-IDX_W){1'b0}}, base_q};
            REG_VICTIM: reg_rdata = {{(DATA_W-IDX_W){1'b0}}, victim};
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_lock_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             do_load,
    input  logic             do_gflush,
    input  logic             do_eflush,
    input  logic [IDX_W-1:0] lock_q,
    input  logic [IDX_W-1:0] base_q,
    input  tlb_entry_t       stage,
    output tlb_entry_t       ent_q [ENTRIES]
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        localparam logic [IDX_W-1:0] SLOT = IDX_W'(i);
        logic targeted;
        logic unprotected;

        assign targeted    = (lock_q == SLOT);
        assign unprotected = (SLOT >= base_q);

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[i] <= '0;
            end else if (do_load && targeted) begin
                ent_q[i] <= stage;
            end else if ((do_eflush && targeted) || (do_gflush && unprotected)) begin
                ent_q[i].valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
    import tlb_lock_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4
) (
    input  tlb_entry_t       ent_q [ENTRIES],
    input  logic             lk_req,
    input  logic             lk_write,
    input  logic [TAG_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_fault,
    output logic [TAG_W-1:0] lk_ppn,
    output perm_e            lk_perm
);

    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]   sel;
    logic               any;
    tlb_entry_t         chosen;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match[i] = ent_q[i].valid && (ent_q[i].vtag == lk_vpn);
    end

    // Lowest matching index wins.
    always_comb begin
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) sel = IDX_W'(i);
        end
    end

    assign any    = |match;
    assign chosen = ent_q[sel];

    always_comb begin
        lk_hit   = lk_req && any;
        lk_miss  = lk_req && !any;
        lk_ppn   = lk_hit ? chosen.ppn  : '0;
        lk_perm  = lk_hit ? chosen.perm : PERM_NONE;
        lk_fault = lk_hit && perm_fault(chosen.perm, lk_write);
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             miss_evt,
    input  logic [IDX_W-1:0] base_q,
    input  logic             base_we,
    input  logic [IDX_W-1:0] base_new,
    output logic [IDX_W-1:0] victim_q
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            victim_q <= '0;
        end else if (base_we) begin
            if (victim_q < base_new) victim_q <= base_new;
        end else if (miss_evt) begin
            victim_q <= (victim_q == LAST) ? base_q : victim_q + 1'b1;
        end
    end

endmodule

// File: rtl/tlb_lock_mgr.sv
module tlb_lock_mgr
    import tlb_lock_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_waddr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [ADDR_W-1:0] reg_raddr,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              lk_req,
    input  logic              lk_write,
    input  logic [TAG_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_fault,
    output logic [TAG_W-1:0]  lk_ppn,
    output logic [1:0]        lk_perm
);

    localparam int IDX_W = $clog2(ENTRIES);

    tlb_entry_t         stage;
    tlb_entry_t         rb_entry;
    tlb_entry_t         ent_q [ENTRIES];
    logic [IDX_W-1:0]   lock_q;
    logic [IDX_W-1:0]   base_q;
    logic [IDX_W-1:0]   base_new;
    logic [IDX_W-1:0]   victim_q;
    logic               base_we;
    logic               do_load;
    logic               do_read;
    logic               do_gflush;
    logic               do_eflush;
    logic [ENTRIES-1:0] ent_valid;
    perm_e              perm_out;

    assign rb_entry = ent_q[lock_q];
    assign lk_perm  = perm_out;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_vld
        assign ent_valid[i] = ent_q[i].valid;
    end

    tlb_regs #(.IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .reg_raddr (reg_raddr),
        .reg_rdata (reg_rdata),
        .rb_entry  (rb_entry),
        .victim    (victim_q),
        .stage     (stage),
        .lock_q    (lock_q),
        .base_q    (base_q),
        .base_we   (base_we),
        .base_new  (base_new),
        .do_load   (do_load),
        .do_read   (do_read),
        .do_gflush (do_gflush),
        .do_eflush (do_eflush)
    );

    tlb_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .do_load   (do_load),
        .do_gflush (do_gflush),
        .do_eflush (do_eflush),
        .lock_q    (lock_q),
        .base_q    (base_q),
        .stage     (stage),
        .ent_q     (ent_q)
    );

    tlb_lookup #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lookup (
        .ent_q    (ent_q),
        .lk_req   (lk_req),
        .lk_write (lk_write),
        .lk_vpn   (lk_vpn),
        .lk_hit   (lk_hit),
        .lk_miss  (lk_miss),
        .lk_fault (lk_fault),
        .lk_ppn   (lk_ppn),
        .lk_perm  (perm_out)
    );

    tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk      (clk),
        .rst      (rst),
        .miss_evt (lk_miss),
        .base_q   (base_q),
        .base_we  (base_we),
        .base_new (base_new),
        .victim_q (victim_q)
    );

endmodule

// File: rtl/tlb_lock_chk.sv
module tlb_lock_chk #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               lk_hit,
    input logic               lk_miss,
    input logic               lk_fault,
    input logic [IDX_W-1:0]   victim_q,
    input logic [IDX_W-1:0]   base_q,
    input logic               base_we,
    input logic               do_gflush,
    input logic               do_eflush,
    input logic [IDX_W-1:0]   lock_q,
    input logic [ENTRIES-1:0] ent_valid
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] unprot_mask;
    logic [IDX_W-1:0]   step_exp;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) unprot_mask[i] = (IDX_W'(i) >= base_q);
    end

    assign step_exp = (victim_q == LAST) ? base_q : victim_q + 1'b1;

    // R4
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(lk_hit && lk_miss));

    // R5
    fault_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        lk_fault |-> lk_hit);

    // R8
    victim_floor_chk: assert property (@(posedge clk) disable iff (rst)
        victim_q >= base_q);

    // R8
    victim_step_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_miss && !base_we) |=> (victim_q == $past(step_exp)));

    // R6
    gflush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        do_gflush |=> ((ent_valid & $past(unprot_mask)) == '0));

    // R7
    eflush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        do_eflush |=> !ent_valid[$past(lock_q)]);

endmodule

bind tlb_lock_mgr tlb_lock_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_hit    (lk_hit),
    .lk_miss   (lk_miss),
    .lk_fault  (lk_fault),
    .victim_q  (victim_q),
    .base_q    (base_q),
    .base_we   (base_we),
    .do_gflush (do_gflush),
    .do_eflush (do_eflush),
    .lock_q    (lock_q),
    .ent_valid (ent_valid)
);

// File: tb/test_tlb_lock_mgr.sv
`timescale 1ns/1ps
module test_tlb_lock_mgr;

    localparam logic [3:0] A_CAM_HI = 4'd0, A_CAM_LO = 4'd1, A_RAM_HI = 4'd2,
                           A_RAM_LO = 4'd3, A_CMD = 4'd4, A_LOCK = 4'd5,
                           A_BASE = 4'd6, A_VICTIM = 4'd7, A_GFLUSH = 4'd8,
                           A_EFLUSH = 4'd9;

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic        hit;
        logic        fault;
        logic [21:0] ppn;
    } vec_t;

    localparam vec_t [0:6] VECS = '{
        '{32'h1234_5400, 1'b1, 1'b1, 1'b0, 22'(32'hABCD_0C00 >> 10)},
        '{32'h0000_0400, 1'b0, 1'b1, 1'b0, 22'(32'h0001_0000 >> 10)},
        '{32'h0000_0400, 1'b1, 1'b1, 1'b1, 22'(32'h0001_0000 >> 10)},
        '{32'h8000_0000, 1'b0, 1'b1, 1'b1, 22'(32'h0002_0400 >> 10)},
        '{32'h1234_5800, 1'b0, 1'b0, 1'b0, 22'h0},
        '{32'hFFFF_FC00, 1'b1, 1'b1, 1'b0, 22'(32'h7777_F800 >> 10)},
        '{32'h1234_0400, 1'b0, 1'b0, 1'b0, 22'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_waddr = '0;
    logic [15:0] reg_wdata = '0;
    logic [3:0]  reg_raddr = '0;
    logic [15:0] reg_rdata;
    logic        lk_req = 1'b0;
    logic        lk_write = 1'b0;
    logic [21:0] lk_vpn = '0;
    logic        lk_hit, lk_miss, lk_fault;
    logic [21:0] lk_ppn;
    logic [1:0]  lk_perm;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tlb_lock_mgr i_tlb_lock_mgr (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .lk_req(lk_req), .lk_write(lk_write), .lk_vpn(lk_vpn),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
        .lk_ppn(lk_ppn), .lk_perm(lk_perm)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [15:0] d);
        reg_raddr = a;
        #1 d = reg_rdata;
    endtask

    task automatic load_entry(int idx, logic [31:0] va, logic [31:0] pa, logic [1:0] perm);
        wr(A_CAM_HI, va[31:16]);
        wr(A_CAM_LO, {va[15:10], 9'b0, 1'b1});
        wr(A_RAM_HI, pa[31:16]);
        wr(A_RAM_LO, {pa[15:10], perm, 8'h00});
        wr(A_LOCK, 16'(idx));
        wr(A_CMD, 16'd1);
    endtask

    task automatic look(logic [31:0] va, logic w, output logic h, output logic m,
                        output logic f, output logic [21:0] p);
        @(negedge clk);
        lk_req = 1'b1; lk_write = w; lk_vpn = va[31:10];
        #1 h = lk_hit; m = lk_miss; f = lk_fault; p = lk_ppn;
        @(negedge clk);
        lk_req = 1'b0; lk_write = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic h, m, f;
        logic [21:0] p;

        do_reset();
        // R10 reset state
        rd(A_VICTIM, d); chk("R10 victim", 32'(d), 32'h0);
        rd(A_BASE, d);   chk("R10 base", 32'(d), 32'h0);
        rd(A_LOCK, d);   chk("R10 lock", 32'(d), 32'h0);
        look(32'h0000_0400, 1'b0, h, m, f, p);
        chk("R10 miss after reset", 32'(m), 32'h1);

        do_reset();
        load_entry(0, 32'h1234_5400, 32'hABCD_0C00, 2'b11);
        load_entry(1, 32'h0000_0400, 32'h0001_0000, 2'b10);
        load_entry(2, 32'h8000_0000, 32'h0002_0400, 2'b00);
        load_entry(3, 32'hFFFF_FC00, 32'h7777_F800, 2'b11);

        // R1 R3 R4 R5 vector walk
        for (int k = 0; k < 7; k++) begin
            look(VECS[k].va, VECS[k].wr, h, m, f, p);
            chk("R1,R3 hit", 32'(h), 32'(VECS[k].hit));
            chk("R4 miss", 32'(m), 32'(!VECS[k].hit));
            chk("R5 fault", 32'(f), 32'(VECS[k].fault));
            chk("R3 ppn", 32'(p), 32'(VECS[k].ppn));
        end
        // R8 two misses from base 0
        rd(A_VICTIM, d); chk("R8 victim after misses", 32'(d), 32'h2);

        // R2 readback of slot 1
        wr(A_LOCK, 16'd1);
        wr(A_CMD, 16'd2);
        rd(A_CAM_HI, d); chk("R2 cam hi", 32'(d), 32'h0000);
        rd(A_CAM_LO, d); chk("R2 cam lo", 32'(d), 32'h0401);
        rd(A_RAM_HI, d); chk("R2 ram hi", 32'(d), 32'h0001);
        rd(A_RAM_LO, d); chk("R2 ram lo", 32'(d), 32'h0200);
        // R9 command reads back 0
        rd(A_CMD, d);    chk("R9 cmd", 32'(d), 32'h0);
        rd(A_GFLUSH, d); chk("R9 gflush", 32'(d), 32'h0);

        // R6 global flush with base 2
        wr(A_BASE, 16'd2);
        wr(A_GFLUSH, 16'd1);
        look(32'h1234_5400, 1'b0, h, m, f, p);
        chk("R6 protected slot0 kept", 32'(h), 32'h1);
        look(32'h0000_0400, 1'b0, h, m, f, p);
        chk("R6 protected slot1 kept", 32'(p), 32'(32'h0001_0000 >> 10));
        look(32'hFFFF_FC00, 1'b0, h, m, f, p);
        chk("R6 slot3 flushed", 32'(m), 32'h1);

        // R7 single flush of protected slot 0
        wr(A_LOCK, 16'd0);
        wr(A_EFLUSH, 16'd1);
        look(32'h1234_5400, 1'b0, h, m, f, p);
        chk("R7 slot0 flushed", 32'(m), 32'h1);
        wr(A_CMD, 16'd2);
        rd(A_CAM_LO, d); chk("R7 slot0 valid bit", 32'(d), 32'h5400);

        // R8 clamp and wrap
        do_reset();
        wr(A_BASE, 16'd14);
        rd(A_VICTIM, d); chk("R8 victim clamp", 32'(d), 32'd14);
        look(32'h0000_0400, 1'b0, h, m, f, p);
        rd(A_VICTIM, d); chk("R8 victim step", 32'(d), 32'd15);
        look(32'h0000_0400, 1'b0, h, m, f, p);
        rd(A_VICTIM, d); chk("R8 victim wrap", 32'(d), 32'd14);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule